// File: doc/BRIEF.md
# Remote Terminal Status Word Builder

This block assembles the 16-bit status word that a serial-bus remote terminal returns after each command. It combines the terminal address with four active-low subsystem indications (busy, subsystem flag, service request, illegal command) and with message-level state: a latched message-error flag and a latched broadcast indication. Turning the word into a bit stream, adding the sync pattern and timing the response are handled by other blocks.

The block also decides whether data may move for the current command. A one-cycle strobe marks that the command word has been transferred. On that strobe the block latches the command's direction bit, subaddress/mode field, mode-code field and broadcast indication, and it samples the illegal input. Busy blocks transmitted data words, except for the two mode commands that return the last command and the built-in-test word. Busy never blocks the transfer of received data to the host.

Top module: `rt_status_builder`

## Requirements
- R1: Status bits 15..11 always equal `rt_addr_i`, and bits 9, 7, 6, 5, 4 and 0 are always 0.
- R2: Status bit 2 (busy) is 1 in the same cycle that `busy_ni` is 0, and 0 when it is 1.
- R3: Status bit 1 (subsystem flag) is 1 in the same cycle that `ssflag_ni` is 0, and 0 when it is 1.
- R4: Status bit 8 (service request) is the inverse of `srvreq_ni`, in the same cycle.
- R5: On the clock edge where `cmd_xfer_i` is 1, status bit 10 (message error) is loaded with the inverse of `illegal_ni`. Changes of `illegal_ni` between strobes have no effect on the word.
- R6: `msg_err_i` high at a clock edge without a strobe sets status bit 10 from the next cycle, and the bit stays set until the next strobe.
- R7: Status bit 3 (broadcast received) is loaded from `cmd_bcast_i` on each strobe and held between strobes.
- R8: After a strobe with `cmd_tx_i`=1, `tx_data_en_o` is 1 while `busy_ni` is 1 and 0 while `busy_ni` is 0, unless R9 applies.
- R9: A transmit command with `cmd_sa_i` equal to 0 or 31 and `cmd_mc_i` equal to 18 or 19 keeps `tx_data_en_o` at 1 while busy is set. The same mode codes under any other subaddress get no exemption, and neither does mode code 17.
- R10: After a strobe with `cmd_tx_i`=0, `rx_xfer_en_o` is 1 and `tx_data_en_o` is 0, whatever the state of busy. After a transmit strobe, `rx_xfer_en_o` is 0.
- R11: After reset and before the first strobe, status bits 10 and 3 are 0 and both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rt_addr_i | input | 5 | Terminal address |
| busy_ni | input | 1 | Busy, active low |
| ssflag_ni | input | 1 | Subsystem flag, active low |
| srvreq_ni | input | 1 | Service request, active low |
| illegal_ni | input | 1 | Illegal command, active low, sampled on the strobe |
| msg_err_i | input | 1 | Internal message error detected |
| cmd_xfer_i | input | 1 | Command word transferred strobe |
| cmd_tx_i | input | 1 | Command direction bit, 1 = transmit |
| cmd_bcast_i | input | 1 | Command was broadcast |
| cmd_sa_i | input | 5 | Subaddress / mode field |
| cmd_mc_i | input | 5 | Mode code / word count field |
| status_word_o | output | 16 | Assembled status word |
| tx_data_en_o | output | 1 | Data words may be transmitted |
| rx_xfer_en_o | output | 1 | Received data may be passed to the host |

## Verification
The bench targets the busy exemption. It checks that mode codes 18 and 19 are exempt under both mode subaddresses, that they are not exempt under an ordinary subaddress, and that mode code 17 is not exempt. A decoder that tests the wrong subaddress or code range would send or hold back data words when it should not. It also moves `illegal_ni` between strobes to catch a design that follows the pin instead of sampling it; such a design would flip the message-error bit in the middle of a message. Finally, it sets busy during a receive command and confirms that received data still reaches the host, which a gate applied without regard to direction would block.

// File: rtl/rtsw_pkg.sv
package rtsw_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned FLD_W  = 5;
  localparam int unsigned WORD_W = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;   // 15..11
    logic              me;     // 10
    logic              z9;
    logic              sr;     // 8
    logic [3:0]        z7_4;
    logic              bcr;    // 3
    logic              busy;   // 2
    logic              ssf;    // 1
    logic              z0;
  } status_t;

  typedef struct packed {
    logic             vld;
    logic             tx;
    logic             bcast;
    logic [FLD_W-1:0] sa;
    logic [FLD_W-1:0] mc;
  } cmd_t;
endpackage

// File: rtl/rtsw_cmd_latch.sv
module rtsw_cmd_latch
  import rtsw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_xfer_i,
  input  logic             cmd_tx_i,
  input  logic             cmd_bcast_i,
  input  logic [FLD_W-1:0] cmd_sa_i,
  input  logic [FLD_W-1:0] cmd_mc_i,
  input  logic             illegal_ni,
  input  logic             msg_err_i,
  output cmd_t             cmd_o,
  output logic             me_o
);
  cmd_t cmd_q;
  logic me_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      me_q  <= 1'b0;
    end else if (cmd_xfer_i) begin
      cmd_q <= '{vld: 1'b1, tx: cmd_tx_i, bcast: cmd_bcast_i, sa: cmd_sa_i, mc: cmd_mc_i};
      me_q  <= ~illegal_ni;          // sample point for illegal
    end else if (msg_err_i) begin
      me_q  <= 1'b1;                 // sticky until next command
    end
  end

  assign cmd_o = cmd_q;
  assign me_o  = me_q;
endmodule

// File: rtl/rtsw_data_gate.sv
module rtsw_data_gate
  import rtsw_pkg::*;
#(
  parameter logic [FLD_W-1:0] MC_TX_LAST = FLD_W'(18),
  parameter logic [FLD_W-1:0] MC_TX_BIT  = FLD_W'(19)
) (
  input  cmd_t cmd_i,
  input  logic busy_i,
  output logic tx_en_o,
  output logic rx_en_o
);
  localparam logic [FLD_W-1:0] SA_MODE_LO = '0;
  localparam logic [FLD_W-1:0] SA_MODE_HI = '1;

  logic is_mode, exempt;

  always_comb begin
    is_mode = (cmd_i.sa == SA_MODE_LO) || (cmd_i.sa == SA_MODE_HI);
    exempt  = is_mode && cmd_i.tx &&
              ((cmd_i.mc == MC_TX_LAST) || (cmd_i.mc == MC_TX_BIT));
    tx_en_o = cmd_i.vld && cmd_i.tx && (exempt || !busy_i);
    rx_en_o = cmd_i.vld && !cmd_i.tx;  // busy never gates host writes
  end
endmodule

// File: rtl/rtsw_pack.sv
module rtsw_pack
  import rtsw_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              me_i,
  input  logic              sr_i,
  input  logic              bcr_i,
  input  logic              busy_i,
  input  logic              ssf_i,
  output logic [WORD_W-1:0] word_o
);
  status_t sw;

  always_comb begin
    sw      = '0;
    sw.addr = addr_i;
    sw.me   = me_i;
    sw.sr   = sr_i;
    sw.bcr  = bcr_i;
    sw.busy = busy_i;
    sw.ssf  = ssf_i;
    word_o  = sw;
  end
endmodule

// File: rtl/rt_status_builder.sv
module rt_status_builder
  import rtsw_pkg::*;
#(
  parameter logic [FLD_W-1:0] MC_TX_LAST = FLD_W'(18),
  parameter logic [FLD_W-1:0] MC_TX_BIT  = FLD_W'(19)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rt_addr_i,
  input  logic              busy_ni,
  input  logic              ssflag_ni,
  input  logic              srvreq_ni,
  input  logic              illegal_ni,
  input  logic              msg_err_i,
  input  logic              cmd_xfer_i,
  input  logic              cmd_tx_i,
  input  logic              cmd_bcast_i,
  input  logic [FLD_W-1:0]  cmd_sa_i,
  input  logic [FLD_W-1:0]  cmd_mc_i,
  output logic [WORD_W-1:0] status_word_o,
  output logic              tx_data_en_o,
  output logic              rx_xfer_en_o
);
  cmd_t cmd;
  logic me;

  rtsw_cmd_latch u_latch (
    .clk_i, .rst_ni, .cmd_xfer_i, .cmd_tx_i, .cmd_bcast_i,
    .cmd_sa_i, .cmd_mc_i, .illegal_ni, .msg_err_i,
    .cmd_o (cmd),
    .me_o  (me)
  );

  rtsw_data_gate #(.MC_TX_LAST(MC_TX_LAST), .MC_TX_BIT(MC_TX_BIT)) u_gate (
    .cmd_i   (cmd),
    .busy_i  (~busy_ni),
    .tx_en_o (tx_data_en_o),
    .rx_en_o (rx_xfer_en_o)
  );

  rtsw_pack u_pack (
    .addr_i (rt_addr_i),
    .me_i   (me),
    .sr_i   (~srvreq_ni),
    .bcr_i  (cmd.bcast),
    .busy_i (~busy_ni),
    .ssf_i  (~ssflag_ni),
    .word_o (status_word_o)
  );
endmodule

// File: rtl/rt_status_builder_chk.sv
module rt_status_builder_chk
  import rtsw_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] rt_addr_i,
  input logic              busy_ni,
  input logic              ssflag_ni,
  input logic              srvreq_ni,
  input logic              illegal_ni,
  input logic              msg_err_i,
  input logic              cmd_xfer_i,
  input logic              cmd_tx_i,
  input logic              cmd_bcast_i,
  input logic [WORD_W-1:0] status_word_o,
  input logic              tx_data_en_o,
  input logic              rx_xfer_en_o
);
  a_r1_layout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_word_o[15:11] == rt_addr_i && status_word_o[9] == 1'b0 &&
    status_word_o[7:4] == 4'b0 && status_word_o[0] == 1'b0);
  a_r2_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_word_o[2] == !busy_ni);
  a_r3_ssflag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_word_o[1] == !ssflag_ni);
  a_r4_srvreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_word_o[8] == !srvreq_ni);
  a_r5_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_xfer_i |=> status_word_o[10] == !$past(illegal_ni));
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_xfer_i && (msg_err_i || status_word_o[10])) |=> status_word_o[10]);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_xfer_i && !msg_err_i) |=> $stable(status_word_o[10]));
  a_r7_bcast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_xfer_i |=> status_word_o[3] == $past(cmd_bcast_i));
  a_r10_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_xfer_i && !cmd_tx_i) |=> (rx_xfer_en_o && !tx_data_en_o));
  a_r10_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_xfer_en_o && tx_data_en_o));
endmodule

bind rt_status_builder rt_status_builder_chk u_chk (
  .clk_i, .rst_ni, .rt_addr_i, .busy_ni, .ssflag_ni, .srvreq_ni, .illegal_ni,
  .msg_err_i, .cmd_xfer_i, .cmd_tx_i, .cmd_bcast_i, .status_word_o,
  .tx_data_en_o, .rx_xfer_en_o
);

// File: tb/tb_rt_status_builder.sv
module tb_rt_status_builder;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [4:0] rt_addr_i = 5'd0, cmd_sa_i = 5'd0, cmd_mc_i = 5'd0;
  logic busy_ni = 1'b1, ssflag_ni = 1'b1, srvreq_ni = 1'b1, illegal_ni = 1'b1;
  logic msg_err_i = 1'b0, cmd_xfer_i = 1'b0, cmd_tx_i = 1'b0, cmd_bcast_i = 1'b0;
  logic [15:0] status_word_o;
  logic tx_data_en_o, rx_xfer_en_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rt_status_builder dut (
    .clk_i(clk), .rst_ni, .rt_addr_i, .busy_ni, .ssflag_ni, .srvreq_ni,
    .illegal_ni, .msg_err_i, .cmd_xfer_i, .cmd_tx_i, .cmd_bcast_i,
    .cmd_sa_i, .cmd_mc_i, .status_word_o, .tx_data_en_o, .rx_xfer_en_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic tx, input logic [4:0] sa, input logic [4:0] mc,
                     input logic bc, input logic ill_n);
    @(negedge clk);
    cmd_tx_i = tx; cmd_sa_i = sa; cmd_mc_i = mc; cmd_bcast_i = bc;
    illegal_ni = ill_n; cmd_xfer_i = 1'b1;
    @(negedge clk);
    cmd_xfer_i = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    check("R11 me", 32'(status_word_o[10]), 0);
    check("R11 bcr", 32'(status_word_o[3]), 0);
    check("R11 en", {30'd0, tx_data_en_o, rx_xfer_en_o}, 0);
  endtask

  task automatic t_fields;
    rt_addr_i = 5'h15; busy_ni = 1'b1; ssflag_ni = 1'b1; srvreq_ni = 1'b1; #1;
    check("R1 idle word", 32'(status_word_o), 32'hA800);
    busy_ni = 1'b0; #1;
    check("R2 busy set", 32'(status_word_o), 32'hA804);
    ssflag_ni = 1'b0; #1;
    check("R3 ssf set", 32'(status_word_o), 32'hA806);
    srvreq_ni = 1'b0; #1;
    check("R4 sr set", 32'(status_word_o), 32'hA906);
    busy_ni = 1'b1; ssflag_ni = 1'b1; srvreq_ni = 1'b1; rt_addr_i = 5'h0A; #1;
    check("R1 R2 R3 R4 clear", 32'(status_word_o), 32'h5000);
  endtask

  task automatic t_busy_gate;
    busy_ni = 1'b1;
    cmd(1'b1, 5'd3, 5'd4, 1'b0, 1'b1);
    check("R8 tx not busy", 32'(tx_data_en_o), 1);
    check("R10 rx off on tx", 32'(rx_xfer_en_o), 0);
    busy_ni = 1'b0; #1;
    check("R8 tx busy", 32'(tx_data_en_o), 0);
    busy_ni = 1'b1;
  endtask

  task automatic t_exempt;
    busy_ni = 1'b0;
    cmd(1'b1, 5'd0, 5'd18, 1'b0, 1'b1);
    check("R9 sa0 mc18", 32'(tx_data_en_o), 1);
    cmd(1'b1, 5'd31, 5'd19, 1'b0, 1'b1);
    check("R9 sa31 mc19", 32'(tx_data_en_o), 1);
    cmd(1'b1, 5'd31, 5'd18, 1'b0, 1'b1);
    check("R9 sa31 mc18", 32'(tx_data_en_o), 1);
    cmd(1'b1, 5'd0, 5'd17, 1'b0, 1'b1);
    check("R9 mc17 not exempt", 32'(tx_data_en_o), 0);
    cmd(1'b1, 5'd5, 5'd18, 1'b0, 1'b1);
    check("R9 sa5 not exempt", 32'(tx_data_en_o), 0);
    cmd(1'b0, 5'd0, 5'd19, 1'b0, 1'b1);
    check("R9 rx mc19 no tx", 32'(tx_data_en_o), 0);
    busy_ni = 1'b1;
  endtask

  task automatic t_rx;
    busy_ni = 1'b0;
    cmd(1'b0, 5'd7, 5'd2, 1'b0, 1'b1);
    check("R10 rx busy", {30'd0, rx_xfer_en_o, tx_data_en_o}, 2);
    busy_ni = 1'b1; #1;
    check("R10 rx idle", {30'd0, rx_xfer_en_o, tx_data_en_o}, 2);
  endtask

  task automatic t_illegal;
    cmd(1'b1, 5'd2, 5'd1, 1'b0, 1'b1);
    check("R5 legal", 32'(status_word_o[10]), 0);
    @(negedge clk); illegal_ni = 1'b0;
    repeat (2) @(negedge clk); #1;
    check("R5 between strobes", 32'(status_word_o[10]), 0);
    cmd(1'b1, 5'd2, 5'd1, 1'b0, 1'b0);
    check("R5 illegal sampled", 32'(status_word_o[10]), 1);
    @(negedge clk); illegal_ni = 1'b1;
    repeat (2) @(negedge clk); #1;
    check("R5 held", 32'(status_word_o[10]), 1);
  endtask

  task automatic t_msg_err;
    cmd(1'b0, 5'd1, 5'd1, 1'b0, 1'b1);
    check("R6 pre", 32'(status_word_o[10]), 0);
    @(negedge clk); msg_err_i = 1'b1;
    #1;
    check("R6 not yet", 32'(status_word_o[10]), 0);
    @(negedge clk); msg_err_i = 1'b0; #1;
    check("R6 set", 32'(status_word_o[10]), 1);
    repeat (3) @(negedge clk); #1;
    check("R6 sticky", 32'(status_word_o[10]), 1);
    cmd(1'b0, 5'd1, 5'd1, 1'b0, 1'b1);
    check("R6 cleared by strobe", 32'(status_word_o[10]), 0);
  endtask

  task automatic t_bcast;
    cmd(1'b0, 5'd4, 5'd3, 1'b1, 1'b1);
    check("R7 bcast set", 32'(status_word_o[3]), 1);
    @(negedge clk); cmd_bcast_i = 1'b0;
    @(negedge clk); #1;
    check("R7 held", 32'(status_word_o[3]), 1);
    cmd(1'b0, 5'd4, 5'd3, 1'b0, 1'b1);
    check("R7 cleared", 32'(status_word_o[3]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_fields();
    t_busy_gate();
    t_exempt();
    t_rx();
    t_illegal();
    t_msg_err();
    t_bcast();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule